// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration

This block is a synchronous two-port random-access memory with a left port and a right port, each able to read or write the shared word array on every clock. Each port presents an active-low enable, a write select (low means write), an address and write data, and receives registered read data. Words are 9 bits wide. The depth is set by an address-width parameter: 14 address bits give 16K words, and the default is kept smaller.

When both ports are enabled on the same word, the block picks one winner and raises a busy flag toward the other port in the same cycle. A write from the flagged port is dropped, so only the winner can change the colliding word. The port whose request was already standing on that word in the previous cycle wins. When both arrive in the same cycle, the left port wins. The winner is kept for as long as the collision lasts.

A mode input selects who decides. In master mode the block arbitrates itself and drives its busy outputs. In slave mode the busy outputs stay low and per-port busy inputs, supplied by an external arbiter, gate the writes instead.

Top module: `dpr_contention_ram`

## Requirements
- R1: The array is written only in a cycle where a port has enable low and write select low. Enable high with write select low changes nothing.
- R2: Read data is registered. When a port is enabled, its read data shows the word at that port's address after the next rising clock edge. While the enable is high, read data holds its value.
- R3: In master mode, when both enables are low and both addresses are equal, exactly one of `l_busy_o` and `r_busy_o` is high in that same cycle.
- R4: Both busy outputs are low whenever the addresses differ or either enable is high. A busy output falls in the same cycle that the collision ends.
- R5: On a new collision, a port that was enabled at the same address in the previous cycle wins over a port that has just arrived. The newcomer gets busy.
- R6: On a new collision where neither port held that request in the previous cycle, the left port wins and `r_busy_o` goes high.
- R7: While a collision lasts from cycle to cycle, the same port keeps winning.
- R8: A write from a port whose busy is in effect does not change the array. The winner's write lands.
- R9: In slave mode (`master_mode`=0) both busy outputs stay low, and a port's write is dropped while its busy input is high. In master mode the busy inputs have no effect.
- R10: A word written through one port can be read through the other port starting with the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: internal arbitration; 0: busy taken from the busy inputs |
| l_ce_n | input | 1 | Left enable, active low |
| l_we_n | input | 1 | Left write select, low means write |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left write block from an external arbiter (slave mode) |
| l_busy_o | output | 1 | Left port lost arbitration (master mode) |
| l_rdata | output | DATA_W | Left registered read data |
| r_ce_n | input | 1 | Right enable, active low |
| r_we_n | input | 1 | Right write select, low means write |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right write block from an external arbiter (slave mode) |
| r_busy_o | output | 1 | Right port lost arbitration (master mode) |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The arbitration is driven in four distinct ways:
- Two fresh requests on one word in the same cycle isolate the fixed left-first tie-break.
- A right-port read held for one cycle before the left port joins separates arrival-order priority from the tie-break.
- Keeping both requests in place for a further cycle separates a held owner from re-arbitration on every cycle, because by then both ports look equally standing.
- Equal and unequal address pairs, and one side moving away, show that busy tracks the address match within the cycle.

Slave-mode runs with the busy inputs set separate external gating from internal arbitration. Cross-port reads after writes show that the array is shared.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/dpr_req_track.sv
// Remembers one port's request from the previous cycle so the arbiter
// can tell a standing request from a fresh one.
module dpr_req_track #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              standing_o
);
  logic              prev_en_q, prev_en_d;
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;

  always_comb begin
    prev_en_d   = en_i;
    prev_addr_d = prev_addr_q;
    if (en_i) prev_addr_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q   <= prev_en_d;
      prev_addr_q <= prev_addr_d;
    end
  end

  assign standing_o = en_i & prev_en_q & (prev_addr_q == addr_i);
endmodule

// File: rtl/dpr_arbiter.sv
// Collision detection and winner selection with owner hold.
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] en_i,
  input  logic [ADDR_W-1:0]    addr_l_i,
  input  logic [ADDR_W-1:0]    addr_r_i,
  input  logic [NUM_PORTS-1:0] standing_i,
  output logic [NUM_PORTS-1:0] busy_o
);
  logic  coll, coll_q;
  side_e owner_q, owner_d, fresh_win, winner;

  always_comb begin
    coll      = en_i[0] & en_i[1] & (addr_l_i == addr_r_i);
    // Right wins a fresh collision only if it alone was already waiting.
    fresh_win = (standing_i[1] & ~standing_i[0]) ? SIDE_R : SIDE_L;
    winner    = coll_q ? owner_q : fresh_win;
    owner_d   = owner_q;
    if (coll) owner_d = winner;
    busy_o[0] = coll & (winner == SIDE_R);
    busy_o[1] = coll & (winner == SIDE_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coll_q  <= 1'b0;
      owner_q <= SIDE_L;
    end else begin
      coll_q  <= coll;
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/dpr_array.sv
// Shared word storage with two write ports and two registered read ports.
module dpr_array
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] en_i,
  input  logic [NUM_PORTS-1:0] we_i,
  input  logic [ADDR_W-1:0]    addr_i  [NUM_PORTS],
  input  logic [DATA_W-1:0]    wdata_i [NUM_PORTS],
  output logic [DATA_W-1:0]    rdata_o [NUM_PORTS]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i[p]) mem[addr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    logic [DATA_W-1:0] rd_q, rd_d;

    always_comb begin
      rd_d = rd_q;
      if (en_i[g]) rd_d = mem[addr_i[g]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
    end

    assign rdata_o[g] = rd_q;
  end
endmodule

// File: rtl/dpr_contention_ram.sv
module dpr_contention_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_PORTS-1:0] en, wr, standing, gen_busy, ext_busy, blk, we;
  logic [ADDR_W-1:0]    addr  [NUM_PORTS];
  logic [DATA_W-1:0]    wdata [NUM_PORTS];
  logic [DATA_W-1:0]    rdata [NUM_PORTS];

  assign en       = {~r_ce_n, ~l_ce_n};
  assign wr       = {~r_we_n, ~l_we_n};
  assign ext_busy = {r_busy_i, l_busy_i};
  assign addr[0]  = l_addr;
  assign addr[1]  = r_addr;
  assign wdata[0] = l_wdata;
  assign wdata[1] = r_wdata;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    dpr_req_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en[g]),
      .addr_i    (addr[g]),
      .standing_o(standing[g])
    );
    assign blk[g] = master_mode ? gen_busy[g] : ext_busy[g];
    assign we[g]  = en[g] & wr[g] & ~blk[g];
  end

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .addr_l_i  (l_addr),
    .addr_r_i  (r_addr),
    .standing_i(standing),
    .busy_o    (gen_busy)
  );

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  assign l_busy_o = master_mode & gen_busy[0];
  assign r_busy_o = master_mode & gen_busy[1];
  assign l_rdata  = rdata[0];
  assign r_rdata  = rdata[1];
endmodule

// File: rtl/dpr_contention_ram_chk.sv
module dpr_contention_ram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_ce_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_o,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_ce_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_o,
  input logic [DATA_W-1:0] r_rdata
);
  logic hit;
  assign hit = !l_ce_n && !r_ce_n && (l_addr == r_addr);

  // R3
  one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit) |-> $onehot({l_busy_o, r_busy_o}));

  // R4
  no_busy_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!l_busy_o && !r_busy_o));

  // R6
  left_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && $past(l_ce_n) && $past(r_ce_n)) |-> (r_busy_o && !l_busy_o));

  // R7
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && $past(master_mode) && $past(hit) && $past(l_busy_o)) |-> l_busy_o);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!l_busy_o && !r_busy_o));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_ce_n |=> $stable(l_rdata));
endmodule

bind dpr_contention_ram dpr_contention_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_mode(master_mode),
  .l_ce_n     (l_ce_n),
  .l_addr     (l_addr),
  .l_busy_o   (l_busy_o),
  .l_rdata    (l_rdata),
  .r_ce_n     (r_ce_n),
  .r_addr     (r_addr),
  .r_busy_o   (r_busy_o),
  .r_rdata    (r_rdata)
);

// File: tb/sim_dpr_contention_ram.sv
`timescale 1ns/1ps
module sim_dpr_contention_ram;
  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_ce_n = 1'b1, l_we_n = 1'b1, l_busy_i = 1'b0;
  logic r_ce_n = 1'b1, r_we_n = 1'b1, r_busy_i = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic l_busy_o, r_busy_o;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpr_contention_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_busy_i(l_busy_i), .l_busy_o(l_busy_o), .l_rdata(l_rdata),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_busy_i(r_busy_i), .r_busy_o(r_busy_o), .r_rdata(r_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drv_l(input logic ce, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce_n = ce; l_we_n = we; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce_n = ce; r_we_n = we; r_addr = a; r_wdata = d;
  endtask

  task automatic idle2();
    drv_l(1, 1, 0, 0); drv_r(1, 1, 0, 0);
    step(); step();
  endtask

  task automatic t_reset();
    #1;
    chk("reset l_rdata", l_rdata, 0);
    chk("reset r_rdata", r_rdata, 0);
    chk("reset busy", {l_busy_o, r_busy_o}, 0);
  endtask

  task automatic t_write_read();
    drv_l(0, 0, 5, 9'h1A5); step();
    drv_l(0, 1, 5, 0); step();
    chk("R2 read after write", l_rdata, 9'h1A5);
    drv_l(1, 0, 5, 9'h0FF); step();
    drv_l(0, 1, 5, 0); step();
    chk("R1 disabled write ignored", l_rdata, 9'h1A5);
    drv_l(1, 1, 7, 0); step();
    chk("R2 rdata holds while disabled", l_rdata, 9'h1A5);
    idle2();
  endtask

  task automatic t_cross();
    drv_r(0, 0, 9, 9'h155); step();
    drv_r(1, 1, 0, 0); drv_l(0, 1, 9, 0); step();
    chk("R10 right write seen on left", l_rdata, 9'h155);
    idle2();
  endtask

  task automatic t_tie();
    drv_l(0, 0, 20, 9'h011); drv_r(0, 0, 20, 9'h022);
    #1;
    chk("R6 tie right busy", r_busy_o, 1);
    chk("R3 tie left free", l_busy_o, 0);
    step();
    idle2();
    drv_r(0, 1, 20, 0); step();
    chk("R8 winner data kept", r_rdata, 9'h011);
    idle2();
  endtask

  task automatic t_earlier();
    drv_l(0, 0, 30, 9'h033); step();
    idle2();
    drv_r(0, 1, 30, 0); step();
    drv_l(0, 0, 30, 9'h0AA);
    #1;
    chk("R5 newcomer left busy", l_busy_o, 1);
    chk("R5 standing right free", r_busy_o, 0);
    step();
    #1;
    chk("R7 owner held", l_busy_o, 1);
    chk("R7 owner held right", r_busy_o, 0);
    step();
    idle2();
    drv_l(0, 1, 30, 0); step();
    chk("R8 blocked write dropped", l_rdata, 9'h033);
    idle2();
  endtask

  task automatic t_diff();
    drv_l(0, 0, 40, 9'h101); drv_r(0, 0, 41, 9'h0F0);
    #1;
    chk("R4 distinct addresses no busy", {l_busy_o, r_busy_o}, 0);
    step();
    drv_l(0, 0, 50, 9'h005); drv_r(0, 1, 50, 0);
    #1;
    chk("R3 collision flagged", r_busy_o, 1);
    step();
    drv_r(0, 1, 51, 0);
    #1;
    chk("R4 busy drops when apart", {l_busy_o, r_busy_o}, 0);
    step();
    idle2();
    drv_l(0, 1, 41, 0); drv_r(0, 1, 40, 0); step();
    chk("R10 left reads right data", l_rdata, 9'h0F0);
    chk("R10 right reads left data", r_rdata, 9'h101);
    idle2();
  endtask

  task automatic t_slave();
    drv_l(0, 0, 60, 9'h012); step();
    idle2();
    master_mode = 1'b0;
    l_busy_i = 1'b1;
    drv_l(0, 0, 60, 9'h1C3); drv_r(0, 1, 60, 0);
    #1;
    chk("R9 slave busy outputs low", {l_busy_o, r_busy_o}, 0);
    step();
    l_busy_i = 1'b0;
    drv_l(1, 1, 0, 0); drv_r(0, 0, 61, 9'h0E1); step();
    idle2();
    drv_l(0, 1, 60, 0); drv_r(0, 1, 61, 0); step();
    chk("R9 external busy blocks write", l_rdata, 9'h012);
    chk("R9 unblocked slave write", r_rdata, 9'h0E1);
    idle2();
    master_mode = 1'b1;
    l_busy_i = 1'b1;
    drv_l(0, 0, 70, 9'h077); step();
    drv_l(0, 1, 70, 0); step();
    chk("R9 busy input ignored in master", l_rdata, 9'h077);
    l_busy_i = 1'b0;
    idle2();
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_write_read();
    t_cross();
    t_tie();
    t_earlier();
    t_diff();
    t_slave();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule